// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital sequencer behind a successive-approximation converter. It runs on the system clock, divides that clock into an ADC clock, and counts half periods of it so that events can fall on either edge. A conversion is started by a software start pulse, by a rising edge on an external trigger when triggering is enabled, or by the end of the previous conversion in free-running mode. Each conversion raises a sample-and-hold strobe, loads the channel selection, steps through ten successive-approximation bit decisions against a comparator input, and stores the result in two byte-wide result registers.

How long a conversion takes, and where it samples, depends on how it was started. The first conversion after enabling is long, to let the analog front end settle. A triggered conversion restarts the prescaler so that its timing is locked to the trigger. A differential conversion started by software is aligned to a half-rate phase clock and may cost one extra ADC clock. The comparator, the DAC and the channel multiplexer are outside the block: the block presents its trial word on `dac_o` and reads back a single comparator bit.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, busy_o, sh_o, mux_upd_o, dec_o, dac_o, chan_o, res_hi_o, res_lo_o and flag_o are all zero.
- R2: A software start with differential mode off begins at the next rising ADC clock edge, samples 1.5 ADC clocks after that edge and completes 13 ADC clocks after it; a pending start is kept until that edge.
- R3: The first conversion after en_i rises samples 14.5 ADC clocks after its start and completes 25 ADC clocks after it.
- R4: While auto_en_i is 1 and the sequencer is idle, a rising edge of trig_i restarts the prescaler and begins a conversion at that clock, which samples 2 ADC clocks later and completes 13.5 ADC clocks later.
- R5: A trig_i edge is ignored while auto_en_i is 0 or a conversion is in progress: no extra conversion and no flag follow it.
- R6: With free_run_i at 1, the next conversion starts at the very half-tick on which the previous one completes, giving back-to-back conversions of 13 ADC clocks each.
- R7: A software-started conversion with diff_i at 1 lasts 14 ADC clocks and samples one ADC clock later than usual when ck2_o (the half-rate phase clock) is 1 at its start, and keeps the 13-clock timing when ck2_o is 0.
- R8: mux_upd_o pulses together with sh_o, and chan_o takes the value of chan_i only at that pulse; later changes of chan_i wait for the next conversion.
- R9: After the sample point, ten one-cycle decision strobes follow one ADC clock apart, bit 9 first and bit 0 last; dec_o has at most one bit set, bit i marks the decision for result bit i, which keeps its trial 1 only if comp_i is 1.
- R10: At completion the 10-bit result is right-aligned across the result pair: res_hi_o holds bits 9:8 in its bits 1:0 with zeros above, res_lo_o holds bits 7:0.
- R11: flag_o goes to 1 at every completion, one system clock after the last half-tick, and holds until a flag_clr_i pulse; a clear in the same cycle as a completion loses.
- R12: busy_o reads 1 from the clock after a start request is accepted or queued until the conversion completes, and stays 1 across free-running restarts.
- R13: Lowering en_i aborts a conversion and clears busy_o without setting flag_o, and the next conversion after en_i returns uses the first-conversion timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable; low aborts and holds the prescaler |
| start_i | input | 1 | Software start pulse |
| auto_en_i | input | 1 | Enables conversion on trig_i rising edges |
| trig_i | input | 1 | External trigger level |
| free_run_i | input | 1 | Restart at each completion |
| diff_i | input | 1 | Differential channel selected |
| chan_i | input | CHAN_W | Requested channel and reference selection |
| comp_i | input | 1 | Comparator decision, 1 when input is at or above dac_o |
| flag_clr_i | input | 1 | Write-one-to-clear for flag_o |
| busy_o | output | 1 | Start bit read-back: conversion queued or running |
| ck2_o | output | 1 | Half-rate phase clock used for differential alignment |
| sh_o | output | 1 | Sample-and-hold strobe |
| mux_upd_o | output | 1 | Channel and reference update strobe |
| chan_o | output | CHAN_W | Channel selection applied to the front end |
| dec_o | output | RES_W | One-hot bit decision strobes |
| dac_o | output | RES_W | Current trial word for the DAC |
| res_hi_o | output | REG_W | Upper result bits, right-aligned |
| res_lo_o | output | REG_W | Lower result bits |
| flag_o | output | 1 | Completion interrupt flag |

## Verification
Conversions are launched in four ways, by a trigger right after enable, by triggers in steady state, by software start with differential mode off and on at both phases of ck2_o, and by free-running restart, and each launch measures the distance from the start to the sample strobe and to the flag. These distances separate the 25, 13, 13.5 and 14 clock variants, since a software start lands in a window of one ADC clock while the others are exact. Comparator input levels of zero, full scale, the two codes either side of mid scale and two alternating-bit codes check every decision in both directions and the split across the result pair. Triggers during a conversion, a clear on the completion cycle and an abort mid-conversion cover the edges of the control flow.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int unsigned HALF_W = 6;
  typedef logic [HALF_W-1:0] half_cnt_t;

  typedef enum logic [1:0] {
    KIND_NORMAL,
    KIND_FIRST,
    KIND_TRIG
  } conv_kind_e;

  // sample point and completion point, in ADC half periods from the start
  typedef struct packed {
    half_cnt_t sh;
    half_cnt_t fin;
  } conv_plan_t;

  localparam half_cnt_t NORM_SH   = 6'd3;
  localparam half_cnt_t NORM_FIN  = 6'd26;
  localparam half_cnt_t FIRST_SH  = 6'd29;
  localparam half_cnt_t FIRST_FIN = 6'd50;
  localparam half_cnt_t TRIG_SH   = 6'd4;
  localparam half_cnt_t TRIG_FIN  = 6'd27;
  localparam half_cnt_t DIFF_SLIP = 6'd2;

  function automatic conv_plan_t plan_for(conv_kind_e kind, logic slip);
    conv_plan_t p;
    case (kind)
      KIND_FIRST: p = '{sh: FIRST_SH, fin: FIRST_FIN};
      KIND_TRIG:  p = '{sh: TRIG_SH,  fin: TRIG_FIN};
      default:    p = '{sh: NORM_SH,  fin: NORM_FIN};
    endcase
    if (slip) begin
      p.sh  = p.sh + DIFF_SLIP;
      p.fin = p.fin + DIFF_SLIP;
    end
    return p;
  endfunction

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o,
  output logic rise_o,
  output logic ck2_o
);

  localparam int unsigned HALF = (DIV >= 2) ? DIV / 2 : 1;
  localparam int unsigned PS_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(HALF - 1);

  logic [PS_W-1:0] ps_q;
  logic            ph_q;  // 0: next tick is a rising ADC edge
  logic            ck2_q;

  assign tick_o = (ps_q == PS_LAST);
  assign rise_o = tick_o & ~ph_q;
  assign ck2_o  = ck2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q  <= '0;
      ph_q  <= 1'b0;
      ck2_q <= 1'b0;
    end else if (clr_i) begin
      // restart counts as a rising edge, so the next tick is a falling one
      ps_q <= '0;
      ph_q <= 1'b1;
    end else begin
      ps_q <= tick_o ? '0 : ps_q + 1'b1;
      if (tick_o) ph_q <= ~ph_q;
      if (rise_o) ck2_q <= ~ck2_q;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned CHAN_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              auto_en_i,
  input  logic              trig_i,
  input  logic              free_run_i,
  input  logic              diff_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              tick_i,
  input  logic              rise_i,
  input  logic              ck2_i,
  output logic              presc_clr_o,
  output logic              busy_o,
  output logic              sh_o,
  output logic              mux_upd_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic [RES_W-1:0]  dec_o,
  output logic              done_o
);

  logic              busy_q, pend_q, first_q, trig_q;
  half_cnt_t         cnt_q;
  conv_plan_t        plan_q;
  logic              sh_q, mux_q, done_q;
  logic [CHAN_W-1:0] chan_q;
  logic [RES_W-1:0]  dec_q, dec_d;

  logic              trig_rise, acc_trig, acc_user, finish, sh_hit;
  half_cnt_t         since_sh;
  logic [HALF_W-2:0] step;
  logic              dec_hit;

  always_comb begin
    trig_rise = auto_en_i & trig_i & ~trig_q;
    acc_trig  = en_i & ~busy_q & trig_rise;
    acc_user  = en_i & ~busy_q & ~acc_trig & (start_i | pend_q) & rise_i;
    finish    = en_i & busy_q & tick_i & (cnt_q == plan_q.fin);
    sh_hit    = en_i & busy_q & tick_i & (cnt_q == plan_q.sh);
    since_sh  = cnt_q - plan_q.sh;
    step      = since_sh[HALF_W-1:1];
    dec_hit   = en_i & busy_q & tick_i & (cnt_q > plan_q.sh) & ~since_sh[0];
    dec_d     = '0;
    for (int i = 0; i < RES_W; i++) begin
      dec_d[i] = dec_hit && (int'(step) == int'(RES_W) - i);
    end
  end

  assign presc_clr_o = acc_trig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      first_q <= 1'b1;
      trig_q  <= 1'b0;
      cnt_q   <= '0;
      plan_q  <= plan_for(KIND_NORMAL, 1'b0);
    end else begin
      trig_q <= trig_i;
      if (!en_i) begin
        busy_q  <= 1'b0;
        pend_q  <= 1'b0;
        first_q <= 1'b1;
        cnt_q   <= '0;
      end else if (acc_trig) begin
        busy_q <= 1'b1;
        pend_q <= 1'b0;
        cnt_q  <= 6'd1;
        plan_q <= plan_for(first_q ? KIND_FIRST : KIND_TRIG, 1'b0);
      end else if (acc_user) begin
        busy_q <= 1'b1;
        pend_q <= 1'b0;
        cnt_q  <= 6'd1;
        plan_q <= plan_for(first_q ? KIND_FIRST : KIND_NORMAL, diff_i & ck2_i);
      end else if (finish) begin
        first_q <= 1'b0;
        if (free_run_i) begin
          cnt_q  <= 6'd1;
          plan_q <= plan_for(KIND_NORMAL, 1'b0);
        end else begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end
      end else begin
        if (busy_q && tick_i) cnt_q <= cnt_q + 1'b1;
        if (!busy_q && start_i) pend_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= 1'b0;
      mux_q  <= 1'b0;
      done_q <= 1'b0;
      dec_q  <= '0;
      chan_q <= '0;
    end else begin
      sh_q   <= sh_hit;
      mux_q  <= sh_hit;
      done_q <= finish;
      dec_q  <= dec_d;
      if (sh_hit) chan_q <= chan_i;
    end
  end

  assign busy_o    = busy_q | pend_q;
  assign sh_o      = sh_q;
  assign mux_upd_o = mux_q;
  assign chan_o    = chan_q;
  assign dec_o     = dec_q;
  assign done_o    = done_q;

  a_r9_dec_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dec_q));

  a_r9_dec_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dec_q) |-> busy_q);

  a_r12_busy_at_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_q |-> busy_o);

  a_r8_chan_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mux_q |-> $stable(chan_q));

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sh_i,
  input  logic [RES_W-1:0] dec_i,
  input  logic             comp_i,
  input  logic             done_i,
  input  logic             clr_i,
  output logic [RES_W-1:0] dac_o,
  output logic [REG_W-1:0] res_hi_o,
  output logic [REG_W-1:0] res_lo_o,
  output logic             flag_o
);

  localparam logic [RES_W-1:0] TRIAL_MSB = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] sar_q, sar_d, res_q;
  logic             flag_q;

  always_comb begin
    sar_d = sar_q;
    if (sh_i) begin
      sar_d = TRIAL_MSB;
    end else begin
      for (int i = 0; i < RES_W; i++) begin
        if (dec_i[i]) sar_d[i] = comp_i;
      end
      for (int i = 1; i < RES_W; i++) begin
        if (dec_i[i]) sar_d[i-1] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q  <= '0;
      res_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      sar_q  <= sar_d;
      if (done_i) res_q <= sar_q;
      flag_q <= done_i | (flag_q & ~clr_i);
    end
  end

  assign dac_o    = sar_q;
  assign res_hi_o = REG_W'(res_q >> REG_W);
  assign res_lo_o = res_q[REG_W-1:0];
  assign flag_o   = flag_q;

  a_r11_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_i |=> flag_q);

  a_r11_flag_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(done_i));

  a_r9_one_decision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_i |-> (dec_i == '0));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int unsigned PRESC_DIV = 4,
  parameter int unsigned RES_W     = 10,
  parameter int unsigned REG_W     = 8,
  parameter int unsigned CHAN_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              auto_en_i,
  input  logic              trig_i,
  input  logic              free_run_i,
  input  logic              diff_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              comp_i,
  input  logic              flag_clr_i,
  output logic              busy_o,
  output logic              ck2_o,
  output logic              sh_o,
  output logic              mux_upd_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic [RES_W-1:0]  dec_o,
  output logic [RES_W-1:0]  dac_o,
  output logic [REG_W-1:0]  res_hi_o,
  output logic [REG_W-1:0]  res_lo_o,
  output logic              flag_o
);

  logic tick, rise, presc_clr, done;

  adc_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (presc_clr | ~en_i),
    .tick_o (tick),
    .rise_o (rise),
    .ck2_o  (ck2_o)
  );

  adc_seq_ctrl #(.RES_W(RES_W), .CHAN_W(CHAN_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .start_i     (start_i),
    .auto_en_i   (auto_en_i),
    .trig_i      (trig_i),
    .free_run_i  (free_run_i),
    .diff_i      (diff_i),
    .chan_i      (chan_i),
    .tick_i      (tick),
    .rise_i      (rise),
    .ck2_i       (ck2_o),
    .presc_clr_o (presc_clr),
    .busy_o      (busy_o),
    .sh_o        (sh_o),
    .mux_upd_o   (mux_upd_o),
    .chan_o      (chan_o),
    .dec_o       (dec_o),
    .done_o      (done)
  );

  adc_sar_reg #(.RES_W(RES_W), .REG_W(REG_W)) u_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sh_i     (sh_o),
    .dec_i    (dec_o),
    .comp_i   (comp_i),
    .done_i   (done),
    .clr_i    (flag_clr_i),
    .dac_o    (dac_o),
    .res_hi_o (res_hi_o),
    .res_lo_o (res_lo_o),
    .flag_o   (flag_o)
  );

endmodule

// File: tb/adc_conv_seq_bench.sv
module adc_conv_seq_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0, start_i = 1'b0, auto_en_i = 1'b0, trig_i = 1'b0;
  logic       free_run_i = 1'b0, diff_i = 1'b0, flag_clr_i = 1'b0;
  logic [4:0] chan_i = '0;
  logic       comp_i;
  logic       busy_o, ck2_o, sh_o, mux_upd_o, flag_o;
  logic [4:0] chan_o;
  logic [9:0] dec_o, dac_o;
  logic [7:0] res_hi_o, res_lo_o;
  logic [9:0] vin = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;
  assign comp_i = (vin >= dac_o);

  adc_conv_seq u_adc_conv_seq (
    .clk_i, .rst_ni, .en_i, .start_i, .auto_en_i, .trig_i, .free_run_i,
    .diff_i, .chan_i, .comp_i, .flag_clr_i, .busy_o, .ck2_o, .sh_o,
    .mux_upd_o, .chan_o, .dec_o, .dac_o, .res_hi_o, .res_lo_o, .flag_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk_i); flag_clr_i = 1'b1;
    @(negedge clk_i); flag_clr_i = 1'b0;
  endtask

  // launch one conversion and time it in system clocks from the launch edge
  task automatic run_conv(input bit use_trig, input int want_ck2, input int retrig_at,
                          input int clr_at, output int n_sh, output int n_flag,
                          output int ndec, output int i_first, output int i_last,
                          output int nbusy);
    int n = 0;
    n_sh = 0; n_flag = 0; ndec = 0; i_first = -1; i_last = -1; nbusy = 0;
    @(negedge clk_i);
    if (want_ck2 >= 0) while (ck2_o != want_ck2[0]) @(negedge clk_i);
    if (use_trig) trig_i = 1'b1; else start_i = 1'b1;
    while (n_flag == 0 && n < 400) begin
      @(posedge clk_i); n++;
      @(negedge clk_i);
      start_i    = 1'b0;
      trig_i     = (retrig_at != 0 && n == retrig_at);
      flag_clr_i = (clr_at != 0 && n == clr_at);
      if (busy_o) nbusy++;
      if (sh_o && n_sh == 0) n_sh = n;
      if (dec_o != '0) begin
        ndec++;
        for (int i = 0; i < 10; i++)
          if (dec_o[i]) begin
            if (i_first < 0) i_first = i;
            i_last = i;
          end
      end
      if (flag_o) n_flag = n;
    end
    trig_i = 1'b0; flag_clr_i = 1'b0;
  endtask

  function automatic bit res_ok(input logic [9:0] v);
    return res_hi_o == {6'b0, v[9:8]} && res_lo_o == v[7:0];
  endfunction

  task automatic t_reset();
    @(negedge clk_i);
    chk(busy_o == 0 && sh_o == 0 && mux_upd_o == 0 && dec_o == 0, "R1 control idle", int'(busy_o), 0);
    chk(dac_o == 0 && chan_o == 0, "R1 dac and channel", int'(dac_o), 0);
    chk(res_hi_o == 0 && res_lo_o == 0 && flag_o == 0, "R1 result and flag", int'(res_lo_o), 0);
  endtask

  task automatic t_first();
    int s, f, d, a, b, bz;
    en_i = 1'b1; auto_en_i = 1'b1; vin = 10'h2AB;
    run_conv(1, -1, 0, 0, s, f, d, a, b, bz);
    chk(s == 59, "R3 first sample point", s, 59);
    chk(f == 102, "R3 first completion", f, 102);
    chk(res_ok(vin), "R10 first result", {res_hi_o, res_lo_o}, int'(vin));
    clear_flag();
  endtask

  task automatic t_trig();
    int s, f, d, a, b, bz;
    logic [9:0] pats [6] = '{10'd0, 10'd1023, 10'd512, 10'd511, 10'h155, 10'h2AA};
    auto_en_i = 1'b1;
    foreach (pats[k]) begin
      vin = pats[k];
      run_conv(1, -1, 0, 0, s, f, d, a, b, bz);
      chk(s == 9, "R4 trigger sample point", s, 9);
      chk(f == 56, "R4 trigger completion", f, 56);
      chk(d == 10 && a == 9 && b == 0, "R9 decision count and order", d * 100 + a * 10 + b, 1090);
      chk(res_ok(vin), "R10 result split", {res_hi_o, res_lo_o}, int'(vin));
      chk(bz == f - 2, "R12 busy span", bz, f - 2);
      clear_flag();
    end
  endtask

  task automatic t_ignore();
    int s, f, d, a, b, bz;
    auto_en_i = 1'b0;
    @(negedge clk_i); trig_i = 1'b1;
    @(negedge clk_i); trig_i = 1'b0;
    repeat (80) @(negedge clk_i);
    chk(busy_o == 0 && flag_o == 0, "R5 trigger with auto off", int'(flag_o), 0);
    auto_en_i = 1'b1; vin = 10'd300;
    run_conv(1, -1, 20, 0, s, f, d, a, b, bz);
    chk(f == 56, "R5 retrigger keeps timing", f, 56);
    clear_flag();
    repeat (80) @(negedge clk_i);
    chk(busy_o == 0 && flag_o == 0, "R5 retrigger leaves no conversion", int'(flag_o), 0);
    auto_en_i = 1'b0;
  endtask

  task automatic t_user();
    int s, f, d, a, b, bz;
    vin = 10'd777;
    run_conv(0, -1, 0, 0, s, f, d, a, b, bz);
    chk(f >= 54 && f <= 57, "R2 software start completion window", f, 54);
    chk(f - s == 47, "R2 sample to completion", f - s, 47);
    chk(bz == f - 2, "R12 busy from start request", bz, f - 2);
    chk(busy_o == 0, "R12 busy clear after completion", int'(busy_o), 0);
    chk(res_ok(vin), "R10 software start result", {res_hi_o, res_lo_o}, int'(vin));
    clear_flag();
  endtask

  task automatic t_diff();
    int s, f, d, a, b, bz;
    diff_i = 1'b1; vin = 10'd100;
    run_conv(0, 1, 0, 0, s, f, d, a, b, bz);
    chk(f >= 58 && f <= 61, "R7 phase high completion", f, 58);
    chk(s >= 11 && s <= 14, "R7 phase high sample point", s, 11);
    chk(res_ok(vin), "R7 phase high result", {res_hi_o, res_lo_o}, int'(vin));
    clear_flag();
    run_conv(0, 0, 0, 0, s, f, d, a, b, bz);
    chk(f >= 54 && f <= 57, "R7 phase low completion", f, 54);
    chk(s >= 7 && s <= 10, "R7 phase low sample point", s, 7);
    clear_flag();
    diff_i = 1'b0;
  endtask

  task automatic t_free();
    int s, f, d, a, b, bz, n;
    free_run_i = 1'b1; vin = 10'd640;
    run_conv(0, -1, 0, 0, s, f, d, a, b, bz);
    flag_clr_i = 1'b1;
    n = 0;
    bz = 1;
    do begin
      @(posedge clk_i); n++;
      @(negedge clk_i); flag_clr_i = 1'b0;
      if (!busy_o) bz = 0;
    end while (!flag_o && n < 200);
    chk(n == 52, "R6 back to back period", n, 52);
    chk(bz == 1, "R12 busy through restart", bz, 1);
    chk(res_ok(vin), "R6 free running result", {res_hi_o, res_lo_o}, int'(vin));
    free_run_i = 1'b0;
    clear_flag();
    n = 0;
    while (!flag_o && n < 200) begin @(negedge clk_i); n++; end
    clear_flag();
    repeat (60) @(negedge clk_i);
    chk(busy_o == 0 && flag_o == 0, "R6 stops when mode drops", int'(busy_o), 0);
  endtask

  task automatic t_chan();
    int n = 0;
    chan_i = 5'd5;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    while (!mux_upd_o && n < 100) begin @(negedge clk_i); n++; end
    chk(sh_o == 1 && chan_o == 5'd5, "R8 channel loaded at sample", int'(chan_o), 5);
    chan_i = 5'd9;
    while (!flag_o && n < 300) begin @(negedge clk_i); n++; end
    chk(chan_o == 5'd5, "R8 late change deferred", int'(chan_o), 5);
    clear_flag();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    n = 0;
    while (!flag_o && n < 300) begin @(negedge clk_i); n++; end
    chk(chan_o == 5'd9, "R8 change applied next conversion", int'(chan_o), 9);
    clear_flag();
  endtask

  task automatic t_w1c();
    int s, f, d, a, b, bz;
    auto_en_i = 1'b1; vin = 10'd42;
    run_conv(1, -1, 0, 55, s, f, d, a, b, bz);
    chk(f == 56, "R11 set wins over clear", f, 56);
    repeat (10) @(negedge clk_i);
    chk(flag_o == 1, "R11 flag holds", int'(flag_o), 1);
    clear_flag();
    chk(flag_o == 0, "R11 write one clears", int'(flag_o), 0);
  endtask

  task automatic t_abort();
    int s, f, d, a, b, bz;
    auto_en_i = 1'b1;
    @(negedge clk_i); trig_i = 1'b1;
    @(negedge clk_i); trig_i = 1'b0;
    repeat (20) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk(busy_o == 0, "R13 abort clears busy", int'(busy_o), 0);
    repeat (100) @(negedge clk_i);
    chk(flag_o == 0, "R13 abort sets no flag", int'(flag_o), 0);
    en_i = 1'b1; vin = 10'd900;
    run_conv(1, -1, 0, 0, s, f, d, a, b, bz);
    chk(f == 102, "R13 first timing after re-enable", f, 102);
    chk(res_ok(vin), "R13 result after re-enable", {res_hi_o, res_lo_o}, int'(vin));
    clear_flag();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_first();
    t_trig();
    t_ignore();
    t_user();
    t_diff();
    t_free();
    t_chan();
    t_w1c();
    t_abort();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule